// File: doc/BRIEF.md
# Center-Aligned Three-Phase PWM Timing Core

This block is the timing heart of a three-phase inverter modulator. A half-period counter climbs from zero towards a programmed half-period and then falls back, and three phases compare their own widths against it. Each phase yields a complementary high-side and low-side drive signal. The signals are centered on the period midpoint and separated by a programmable dead band. Pulses shorter than a programmed minimum are removed, and in that case the complementary signal takes the whole half.

Software writes the half-period, dead time, minimum pulse, sync width, three duty values and an update-mode bit through a small write port. All of these are copied into working shadows at the start of every period. In double-update mode they are copied again at the turnaround, so the two halves may differ in length and in duty. A sync pulse with a one-cycle strobe marks each copy point. A half flag shows which half is running. A synchronous halt request stops everything and waits for fresh configuration.

The control is a three-state machine:
- ST_WAIT_ARM: idle, all outputs low.
- ST_RISE_HALF: counter rising, first half.
- ST_FALL_HALF: counter falling, second half.

The transitions are:
- ST_WAIT_ARM to ST_RISE_HALF once the arming writes are complete.
- ST_RISE_HALF to ST_FALL_HALF on the last rising tick.
- ST_FALL_HALF to ST_RISE_HALF on the last falling tick.
- Any state to ST_WAIT_ARM on a halt request.

Top module: `cpwm_core`

## Requirements
- R1: After reset all six phase outputs, sync_pulse, sync_irq and second_half are 0. Nothing is driven until the half-period register (address 0) and the three duty registers (addresses 4, 5, 6 for phases 0, 1, 2) have each been written. Running begins on the clock edge after the last of these four writes is captured.
- R2: Write addresses are 0 half-period P, 1 dead time (10 bits), 2 minimum pulse, 3 sync width (8 bits) and 7 mode (bit 0; 1 selects double update). A half-period below 2 acts as 2. In single-update mode a period lasts 2·P clocks, and sync_irq pulses once per period on its first clock.
- R3: With duty D and dead time T, the high-side width per half is W = D − T, clamped to 0..P. The high output is on for the last W clocks of the first half and the first W clocks of the second half, so it is on for 2·W clocks in a single-update period.
- R4: The low-side width per half is L = P − D − T, clamped to 0..P. The low output is on for the first L clocks of the first half and the last L clocks of the second half. A phase's high and low outputs are never both 1.
- R5: If W is below the minimum-pulse value, the high side is off for that half and the low side is on for the whole half. Otherwise, if L is below the minimum, the low side is off and the high side is on for the whole half.
- R6: In double-update mode every register is copied again at the turnaround. The second half then uses its own P, D and T, so a period lasts P1+P2 clocks and the high side is on for (D1−T1)+(D2−T2) clocks. A second sync_irq occurs on the first clock of the second half.
- R7: sync_pulse rises together with sync_irq at each copy point and stays high for S+1 clocks, where S is the sync width. S resets to 39.
- R8: second_half is 0 throughout the first half and 1 throughout the second half of every period.
- R9: A halt request sampled high drives all outputs low on the next clock and returns the core to idle. Running resumes only after the half-period and all three duty registers are written again.
- R10: In single-update mode, writes made during a period do not change that period. They take effect at the next period start.
- R11: The mode bit resets to single update, so after reset only one sync_irq occurs per period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one tick is one timing unit |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Write data |
| halt_req | input | 1 | Synchronous shutdown and re-arm request |
| phase_hi | output | 3 | High-side drive, one bit per phase |
| phase_lo | output | 3 | Low-side drive, one bit per phase |
| sync_pulse | output | 1 | Sync pulse of programmable width |
| sync_irq | output | 1 | One-clock strobe at each copy point |
| second_half | output | 1 | 1 while the second half of the period runs |

## Verification
The hardest situation to reach is a double-update period whose two halves differ. It needs a write that lands in the first half, after the period-start copy but before the turnaround. The bench therefore aligns to a period-start strobe and injects the write a fixed few clocks later, inside the counting window. It then checks the asymmetric on-times against the two sets of values. Halt re-arming is driven with a partial set of writes, which must leave the core idle until the last duty write arrives. A behavioural tick-by-tick model compares every output on every clock.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [1:0] {
        ST_WAIT_ARM  = 2'd0,
        ST_RISE_HALF = 2'd1,
        ST_FALL_HALF = 2'd2
    } run_state_t;

    localparam logic [ADDR_W-1:0] REG_HALF_PERIOD = 3'd0;
    localparam logic [ADDR_W-1:0] REG_DEAD        = 3'd1;
    localparam logic [ADDR_W-1:0] REG_MIN_PULSE   = 3'd2;
    localparam logic [ADDR_W-1:0] REG_SYNC_WIDTH  = 3'd3;
    localparam logic [ADDR_W-1:0] REG_DUTY_BASE   = 3'd4;
    localparam logic [ADDR_W-1:0] REG_MODE        = 3'd7;

endpackage

// File: rtl/cpwm_regs.sv
module cpwm_regs
    import cpwm_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DT_W   = 10,
    parameter int SW_W   = 8,
    parameter int PHASES = 3,
    parameter int SW_RST = 39
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [CNT_W-1:0]              wr_data,
    input  logic                          halt_req,
    output logic [CNT_W-1:0]              prog_period,
    output logic [DT_W-1:0]               prog_dead,
    output logic [CNT_W-1:0]              prog_minp,
    output logic [SW_W-1:0]               prog_syncw,
    output logic [PHASES-1:0][CNT_W-1:0]  prog_duty,
    output logic                          prog_double,
    output logic                          armed
);

    logic              period_seen;
    logic [PHASES-1:0] duty_seen;

    // configuration storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prog_period <= '0;
            prog_dead   <= '0;
            prog_minp   <= '0;
            prog_syncw  <= SW_W'(SW_RST);
            prog_duty   <= '0;
            prog_double <= 1'b0;
        end else if (wr_en) begin
            if (wr_addr == REG_HALF_PERIOD) prog_period <= wr_data;
            if (wr_addr == REG_DEAD)        prog_dead   <= wr_data[DT_W-1:0];
            if (wr_addr == REG_MIN_PULSE)   prog_minp   <= wr_data;
            if (wr_addr == REG_SYNC_WIDTH)  prog_syncw  <= wr_data[SW_W-1:0];
            if (wr_addr == REG_MODE)        prog_double <= wr_data[0];
            for (int i = 0; i < PHASES; i++) begin
                if (wr_addr == ADDR_W'(REG_DUTY_BASE + ADDR_W'(i)))
                    prog_duty[i] <= wr_data;
            end
        end
    end

    // arming flags: half-period plus every duty since reset or halt
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            period_seen <= 1'b0;
            duty_seen   <= '0;
        end else if (halt_req) begin
            period_seen <= 1'b0;
            duty_seen   <= '0;
        end else if (wr_en) begin
            if (wr_addr == REG_HALF_PERIOD) period_seen <= 1'b1;
            for (int i = 0; i < PHASES; i++) begin
                if (wr_addr == ADDR_W'(REG_DUTY_BASE + ADDR_W'(i)))
                    duty_seen[i] <= 1'b1;
            end
        end
    end

    assign armed = period_seen & (&duty_seen);

endmodule

// File: rtl/cpwm_width_calc.sv
module cpwm_width_calc #(
    parameter int CNT_W = 16,
    parameter int DT_W  = 10
) (
    input  logic [CNT_W-1:0] half_period,
    input  logic [CNT_W-1:0] duty,
    input  logic [CNT_W-1:0] min_pulse,
    input  logic [DT_W-1:0]  dead,
    output logic [CNT_W-1:0] hi_width,
    output logic [CNT_W-1:0] lo_width
);

    localparam int WW = CNT_W + 2;

    logic signed [WW-1:0] p_s, d_s, t_s, m_s;
    logic signed [WW-1:0] hi_raw, lo_raw, hi_clip, lo_clip;

    always_comb begin
        p_s = $signed({2'b00, half_period});
        d_s = $signed({2'b00, duty});
        m_s = $signed({2'b00, min_pulse});
        t_s = $signed({{(WW-DT_W){1'b0}}, dead});

        hi_raw = d_s - t_s;
        lo_raw = p_s - d_s - t_s;

        if (hi_raw < 0)        hi_clip = '0;
        else if (hi_raw > p_s) hi_clip = p_s;
        else                   hi_clip = hi_raw;

        if (lo_raw < 0)        lo_clip = '0;
        else                   lo_clip = lo_raw;

        if (hi_clip < m_s) begin
            hi_width = '0;
            lo_width = half_period;
        end else if (lo_clip < m_s) begin
            hi_width = half_period;
            lo_width = '0;
        end else begin
            hi_width = hi_clip[CNT_W-1:0];
            lo_width = lo_clip[CNT_W-1:0];
        end
    end

endmodule

// File: rtl/cpwm_sync_gen.sv
module cpwm_sync_gen #(
    parameter int SW_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            halt,
    input  logic            fire,
    input  logic [SW_W-1:0] width,
    output logic            pulse,
    output logic            strobe
);

    logic [SW_W-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pulse  <= 1'b0;
            strobe <= 1'b0;
            remain <= '0;
        end else if (halt) begin
            pulse  <= 1'b0;
            strobe <= 1'b0;
            remain <= '0;
        end else if (fire) begin
            pulse  <= 1'b1;
            strobe <= 1'b1;
            remain <= width;
        end else begin
            strobe <= 1'b0;
            if (pulse) begin
                if (remain == '0) pulse  <= 1'b0;
                else              remain <= remain - SW_W'(1);
            end
        end
    end

endmodule

// File: rtl/cpwm_core.sv
module cpwm_core
    import cpwm_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DT_W   = 10,
    parameter int SW_W   = 8,
    parameter int PHASES = 3,
    parameter int SW_RST = 39
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              halt_req,
    output logic [PHASES-1:0] phase_hi,
    output logic [PHASES-1:0] phase_lo,
    output logic              sync_pulse,
    output logic              sync_irq,
    output logic              second_half
);

    localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);
    localparam logic [CNT_W-1:0] MIN_HALF = CNT_W'(2);

    logic [CNT_W-1:0]             prog_period, prog_minp;
    logic [DT_W-1:0]              prog_dead;
    logic [SW_W-1:0]              prog_syncw;
    logic [PHASES-1:0][CNT_W-1:0] prog_duty;
    logic                         prog_double, armed;

    logic [CNT_W-1:0]             eff_period;
    logic [PHASES-1:0][CNT_W-1:0] calc_hi, calc_lo;

    run_state_t                   state, state_nx;
    logic [CNT_W-1:0]             cnt, cnt_nx;
    logic [CNT_W-1:0]             act_period;
    logic [PHASES-1:0][CNT_W-1:0] act_hi, act_lo;
    logic                         act_double;
    logic                         latch_full, latch_mid, sync_fire;

    cpwm_regs #(
        .CNT_W (CNT_W),
        .DT_W  (DT_W),
        .SW_W  (SW_W),
        .PHASES(PHASES),
        .SW_RST(SW_RST)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .halt_req   (halt_req),
        .prog_period(prog_period),
        .prog_dead  (prog_dead),
        .prog_minp  (prog_minp),
        .prog_syncw (prog_syncw),
        .prog_duty  (prog_duty),
        .prog_double(prog_double),
        .armed      (armed)
    );

    assign eff_period = (prog_period < MIN_HALF) ? MIN_HALF : prog_period;

    // per-phase width computation from the programmed values
    for (genvar g = 0; g < PHASES; g++) begin : g_phase
        cpwm_width_calc #(
            .CNT_W(CNT_W),
            .DT_W (DT_W)
        ) u_calc (
            .half_period(eff_period),
            .duty       (prog_duty[g]),
            .min_pulse  (prog_minp),
            .dead       (prog_dead),
            .hi_width   (calc_hi[g]),
            .lo_width   (calc_lo[g])
        );
    end

    // next-state and counter decisions
    always_comb begin
        state_nx   = state;
        cnt_nx     = cnt;
        latch_full = 1'b0;
        latch_mid  = 1'b0;
        unique case (state)
            ST_WAIT_ARM: begin
                if (armed) begin
                    state_nx   = ST_RISE_HALF;
                    cnt_nx     = '0;
                    latch_full = 1'b1;
                end
            end
            ST_RISE_HALF: begin
                if (cnt == act_period - ONE) begin
                    state_nx  = ST_FALL_HALF;
                    latch_mid = act_double;
                    cnt_nx    = (act_double ? eff_period : act_period) - ONE;
                end else begin
                    cnt_nx = cnt + ONE;
                end
            end
            ST_FALL_HALF: begin
                if (cnt == '0) begin
                    state_nx   = ST_RISE_HALF;
                    cnt_nx     = '0;
                    latch_full = 1'b1;
                end else begin
                    cnt_nx = cnt - ONE;
                end
            end
            default: state_nx = ST_WAIT_ARM;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        state <= ST_WAIT_ARM;
        else if (halt_req) state <= ST_WAIT_ARM;
        else               state <= state_nx;
    end

    // counter and working shadows
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt        <= '0;
            act_period <= MIN_HALF;
            act_hi     <= '0;
            act_lo     <= '0;
            act_double <= 1'b0;
        end else if (halt_req) begin
            cnt <= '0;
        end else begin
            cnt <= cnt_nx;
            if (latch_full || latch_mid) begin
                act_period <= eff_period;
                act_hi     <= calc_hi;
                act_lo     <= calc_lo;
            end
            if (latch_full) act_double <= prog_double;
        end
    end

    assign sync_fire = (latch_full | latch_mid) & ~halt_req;

    cpwm_sync_gen #(
        .SW_W(SW_W)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .halt  (halt_req),
        .fire  (sync_fire),
        .width (prog_syncw),
        .pulse (sync_pulse),
        .strobe(sync_irq)
    );

    // outputs
    always_comb begin
        phase_hi    = '0;
        phase_lo    = '0;
        second_half = 1'b0;
        unique case (state)
            ST_WAIT_ARM: begin
                second_half = 1'b0;
            end
            ST_RISE_HALF, ST_FALL_HALF: begin
                for (int i = 0; i < PHASES; i++) begin
                    phase_hi[i] = ({1'b0, cnt} + {1'b0, act_hi[i]}) >= {1'b0, act_period};
                    phase_lo[i] = cnt < act_lo[i];
                end
                second_half = (state == ST_FALL_HALF);
            end
            default: second_half = 1'b0;
        endcase
    end

endmodule

// File: rtl/cpwm_checker.sv
module cpwm_checker #(
    parameter int PHASES = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              halt_req,
    input logic [PHASES-1:0] phase_hi,
    input logic [PHASES-1:0] phase_lo,
    input logic              sync_pulse,
    input logic              sync_irq,
    input logic              second_half
);

    for (genvar g = 0; g < PHASES; g++) begin : g_pair
        AST_PAIR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
            !(phase_hi[g] && phase_lo[g])); // R4
    end

    AST_QUIET_AFTER_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(halt_req) |-> (phase_hi == '0 && phase_lo == '0 && !sync_pulse && !second_half)); // R9

    AST_STROBE_INSIDE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        sync_irq |-> sync_pulse); // R7

    AST_PULSE_RISES_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_pulse) |-> sync_irq); // R7

    AST_PERIOD_START_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(second_half) && !$past(halt_req)) |-> sync_irq); // R8

    AST_STROBE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        sync_irq |=> !sync_irq); // R2

endmodule

bind cpwm_core cpwm_checker #(.PHASES(PHASES)) u_cpwm_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .halt_req   (halt_req),
    .phase_hi   (phase_hi),
    .phase_lo   (phase_lo),
    .sync_pulse (sync_pulse),
    .sync_irq   (sync_irq),
    .second_half(second_half)
);

// File: tb/test_cpwm_core.sv
module test_cpwm_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        halt_req = 1'b0;
    logic [2:0]  phase_hi, phase_lo;
    logic        sync_pulse, sync_irq, second_half;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    cpwm_core i_cpwm_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .halt_req   (halt_req),
        .phase_hi   (phase_hi),
        .phase_lo   (phase_lo),
        .sync_pulse (sync_pulse),
        .sync_irq   (sync_irq),
        .second_half(second_half)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // ---------------- behavioural reference model ----------------
    int p_per, p_dt, p_minp, p_sw, p_mode;
    int p_duty[3];
    bit f_per;
    bit f_d[3];
    int m_run, m_half, m_k, m_P, m_dbl, m_son, m_srem, m_irq;
    int m_W[3];
    int m_L[3];
    bit ev_start, ev_mid;

    task automatic widths(input int P, input int d, input int dt, input int mp,
                          output int w, output int l);
        w = d - dt;
        if (w < 0) w = 0;
        if (w > P) w = P;
        l = P - d - dt;
        if (l < 0) l = 0;
        if (w < mp)      begin w = 0; l = P; end
        else if (l < mp) begin l = 0; w = P; end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            p_per = 0; p_dt = 0; p_minp = 0; p_sw = 39; p_mode = 0;
            for (int i = 0; i < 3; i++) begin p_duty[i] = 0; f_d[i] = 0; m_W[i] = 0; m_L[i] = 0; end
            f_per = 0;
            m_run = 0; m_half = 0; m_k = 0; m_P = 2; m_dbl = 0;
            m_son = 0; m_srem = 0; m_irq = 0;
        end else begin
            ev_start = 0;
            ev_mid   = 0;
            if (halt_req) begin
                m_run = 0; m_half = 0; m_k = 0;
                f_per = 0;
                for (int i = 0; i < 3; i++) f_d[i] = 0;
                m_son = 0; m_irq = 0;
            end else begin
                if (m_run == 0) begin
                    if (f_per && f_d[0] && f_d[1] && f_d[2]) ev_start = 1;
                end else if (m_half == 0) begin
                    if (m_k == m_P - 1) begin
                        m_half = 1; m_k = 0;
                        if (m_dbl != 0) ev_mid = 1;
                    end else m_k++;
                end else begin
                    if (m_k == m_P - 1) ev_start = 1;
                    else m_k++;
                end
                if (ev_start) begin
                    m_run = 1; m_half = 0; m_k = 0; m_dbl = p_mode;
                end
                if (ev_start || ev_mid) begin
                    m_P = (p_per < 2) ? 2 : p_per;
                    for (int i = 0; i < 3; i++) widths(m_P, p_duty[i], p_dt, p_minp, m_W[i], m_L[i]);
                    m_son = 1; m_srem = p_sw; m_irq = 1;
                end else begin
                    m_irq = 0;
                    if (m_son != 0) begin
                        if (m_srem == 0) m_son = 0;
                        else m_srem--;
                    end
                end
                if (wr_en) begin
                    if (wr_addr == 3'd0) f_per = 1;
                    for (int i = 0; i < 3; i++) if (int'(wr_addr) == 4 + i) f_d[i] = 1;
                end
            end
            if (wr_en) begin
                case (wr_addr)
                    3'd0: p_per  = int'(wr_data);
                    3'd1: p_dt   = int'(wr_data) % 1024;
                    3'd2: p_minp = int'(wr_data);
                    3'd3: p_sw   = int'(wr_data) % 256;
                    3'd4: p_duty[0] = int'(wr_data);
                    3'd5: p_duty[1] = int'(wr_data);
                    3'd6: p_duty[2] = int'(wr_data);
                    default: p_mode = int'(wr_data) % 2;
                endcase
            end
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int exp_hi, exp_lo;
            exp_hi = 0;
            exp_lo = 0;
            if (m_run != 0) begin
                for (int i = 0; i < 3; i++) begin
                    if (m_half == 0) begin
                        if (m_k >= m_P - m_W[i]) exp_hi |= (1 << i);
                        if (m_k <  m_L[i])       exp_lo |= (1 << i);
                    end else begin
                        if (m_k <  m_W[i])       exp_hi |= (1 << i);
                        if (m_k >= m_P - m_L[i]) exp_lo |= (1 << i);
                    end
                end
            end
            chk("R3 model phase_hi", int'(phase_hi), exp_hi);
            chk("R4 model phase_lo", int'(phase_lo), exp_lo);
            chk("R7 model sync_pulse", int'(sync_pulse), m_son);
            chk("R2 model sync_irq", int'(sync_irq), m_irq);
            chk("R8 model second_half", int'(second_half), (m_run != 0 && m_half == 1) ? 1 : 0);
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !done) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            finish_run();
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = 16'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_start();
        for (int n = 0; n < 400; n++) begin
            @(negedge clk);
            if (sync_irq && !second_half) return;
        end
        chk("R2 period start seen", 0, 1);
    endtask

    task automatic measure(input int n, input bit do_wr, input int wa, input int wd,
                           output int hi[3], output int lo[3],
                           output int irqs, output int spw, output int sec);
        for (int i = 0; i < 3; i++) begin hi[i] = 0; lo[i] = 0; end
        irqs = 0; spw = 0; sec = 0;
        wait_start();
        for (int j = 0; j < n; j++) begin
            if (j > 0) @(negedge clk);
            for (int i = 0; i < 3; i++) begin
                hi[i] += int'(phase_hi[i]);
                lo[i] += int'(phase_lo[i]);
            end
            irqs += int'(sync_irq);
            spw  += int'(sync_pulse);
            sec  += int'(second_half);
            if (do_wr && j == 5) begin wr_en = 1'b1; wr_addr = 3'(wa); wr_data = 16'(wd); end
            if (do_wr && j == 6) wr_en = 1'b0;
        end
    endtask

    task automatic idle_activity(input int n, output int act);
        act = 0;
        for (int j = 0; j < n; j++) begin
            @(negedge clk);
            act += int'(phase_hi != 0) + int'(phase_lo != 0) + int'(sync_pulse) + int'(sync_irq);
        end
    endtask

    initial begin
        int hi[3];
        int lo[3];
        int irqs, spw, sec, act;

        repeat (3) @(negedge clk);
        chk("R1 reset phase_hi", int'(phase_hi), 0);
        chk("R1 reset phase_lo", int'(phase_lo), 0);
        chk("R1 reset sync_pulse", int'(sync_pulse), 0);
        chk("R1 reset sync_irq", int'(sync_irq), 0);
        chk("R1 reset second_half", int'(second_half), 0);
        rst_n = 1'b1;

        // partial configuration: must stay idle
        wr(0, 30); wr(1, 2); wr(4, 8); wr(5, 15);
        idle_activity(40, act);
        chk("R1 idle before arming", act, 0);
        wr(6, 40);

        // single update, default sync width
        measure(60, 0, 0, 0, hi, lo, irqs, spw, sec);
        chk("R3 hi phase0", hi[0], 12);
        chk("R3 hi phase1", hi[1], 26);
        chk("R3 hi phase2 clamped", hi[2], 60);
        chk("R4 lo phase0", lo[0], 40);
        chk("R4 lo phase1", lo[1], 26);
        chk("R4 lo phase2 clamped", lo[2], 0);
        chk("R11 one irq per period after reset", irqs, 1);
        chk("R7 default sync width", spw, 40);
        chk("R8 second half length", sec, 30);

        // mid-period duty write does not affect current period
        measure(60, 1, 4, 12, hi, lo, irqs, spw, sec);
        chk("R10 hi phase0 unchanged", hi[0], 12);
        chk("R10 lo phase0 unchanged", lo[0], 40);

        measure(60, 1, 3, 4, hi, lo, irqs, spw, sec);
        chk("R3 new duty hi phase0", hi[0], 20);
        chk("R4 new duty lo phase0", lo[0], 32);
        chk("R10 sync width unchanged", spw, 40);
        chk("R2 single irq count", irqs, 1);

        measure(60, 0, 0, 0, hi, lo, irqs, spw, sec);
        chk("R7 sync width S+1", spw, 5);

        // minimum pulse deletion
        wr(2, 5); wr(4, 5); wr(5, 25);
        measure(60, 0, 0, 0, hi, lo, irqs, spw, sec);
        chk("R5 high deleted", hi[0], 0);
        chk("R5 low full", lo[0], 60);
        chk("R5 high full", hi[1], 60);
        chk("R5 low deleted", lo[1], 0);

        // double update with a half-period change at the turnaround
        wr(2, 0); wr(4, 12); wr(5, 15); wr(7, 1);
        measure(50, 1, 0, 20, hi, lo, irqs, spw, sec);
        chk("R6 hi phase0", hi[0], 20);
        chk("R6 lo phase0 asym", lo[0], 22);
        chk("R6 hi phase1", hi[1], 26);
        chk("R6 lo phase1 asym", lo[1], 16);
        chk("R6 two irqs", irqs, 2);
        chk("R8 second half length double", sec, 20);
        chk("R7 two sync pulses", spw, 10);

        // asymmetric duty within one period
        measure(40, 1, 4, 16, hi, lo, irqs, spw, sec);
        chk("R6 asym duty hi", hi[0], 24);
        chk("R6 asym duty lo", lo[0], 8);

        // halt and re-arm
        wait_start();
        repeat (3) @(negedge clk);
        halt_req = 1'b1;
        @(negedge clk);
        halt_req = 1'b0;
        chk("R9 outputs low after halt", int'(phase_hi) + int'(phase_lo) + int'(sync_pulse), 0);
        wr(0, 20); wr(4, 12); wr(5, 15);
        idle_activity(40, act);
        chk("R9 idle until fully rewritten", act, 0);
        wr(6, 40);
        measure(40, 0, 0, 0, hi, lo, irqs, spw, sec);
        chk("R9 resumed hi phase0", hi[0], 20);
        chk("R9 resumed irq count", irqs, 2);

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule